// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Store

This block is a read-only data cache for a processor load path. Its main array is direct mapped: each word address selects exactly one line slot through its index field, and the tag stored there decides hit or miss. Alongside the main array sits a small fully associative victim store. It keeps lines that fills recently pushed out of the main array, so two or more hot lines that collide on one index do not keep going back to memory.

A request is taken on a valid/ready handshake. A main-array hit answers on the next cycle. On a main-array miss, every victim entry is compared at once against the requested line address. On a victim hit, the victim line and the line occupying the main slot trade places in a single extra cycle, and no memory traffic is generated. Only a miss in both structures sends a line request to the next level. The returned line is written into the main slot, and the line it displaces is pushed into the victim store. Three counters report main hits, victim hits and memory fills.

Top module: `dmc_victim_cache`

## Requirements
- R1: After reset, every main-array and victim-store entry is invalid, the three counters read zero, `req_ready` is high and `rsp_valid` and `fill_req_valid` are low.
- R2: A word address splits into the word offset (lowest OFF_W bits), the index (next IDX_W bits) and the tag (remaining upper bits). On a main-array hit, `rsp_valid` pulses with the addressed word in the cycle after the request is accepted.
- R3: On a main-array miss, all victim entries are compared in parallel against the line address (word address shifted right by OFF_W). At most one entry matches. A victim hit issues no fill request and answers two cycles after acceptance.
- R4: A fill request is raised only when both the main array and the victim store miss. `fill_req_line` carries the line address, and the request holds stable until `fill_req_ready`. Word w of `fill_rsp_data` sits at bits [w*WORD_W +: WORD_W]. `rsp_valid` pulses in the cycle after the accepted `fill_rsp_valid` beat.
- R5: When a fill replaces a valid main line, that line goes to the victim entry named by a rotating pointer. The pointer starts at entry 0 and advances by one (wrapping) on each such insertion, so entries are reused in insertion (FIFO) order.
- R6: On a victim hit, the victim line moves into the main slot and the displaced main line takes the freed victim entry. The rotating pointer does not move.
- R7: `cnt_main_hit`, `cnt_victim_hit` and `cnt_fill` each rise by exactly one per main hit, victim hit and completed fill respectively. They change at no other time.
- R8: `req_ready` is low from the cycle after a missing request is accepted until the cycle its response is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | WORD_W | Returned word |
| fill_req_valid | output | 1 | Line request to next level |
| fill_req_ready | input | 1 | Next level accepts the line request |
| fill_req_line | output | ADDR_W-OFF_W | Line address requested |
| fill_rsp_valid | input | 1 | Line data beat from next level |
| fill_rsp_data | input | WORD_W*LINE_WORDS | Whole line, word 0 in the low bits |
| cnt_main_hit | output | CNT_W | Main-array hit count |
| cnt_victim_hit | output | CNT_W | Victim-store hit count |
| cnt_fill | output | CNT_W | Completed memory fill count |

## Verification
The bench builds the block with its defaults: 12-bit word addresses, four-word lines, eight sets and four victim entries. Random addresses are drawn from only four of the sets and eight tags. This keeps several lines fighting over each slot, so the victim store fills up and the FIFO pointer wraps many times. It also produces victim hits whose displaced line lands in a non-pointer entry, and revisits of lines that FIFO order has already evicted. Fill-ready and fill-response delays are random, which keeps the request hold-until-accept rule and the response timing in play.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_FREQ  = 2'd2,
        ST_FWAIT = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_main_array.sv
module dmc_main_array #(
    parameter int SETS      = 8,
    parameter int TAG_W     = 7,
    parameter int LINE_BITS = 128,
    localparam int IDX_W    = $clog2(SETS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [LINE_BITS-1:0] rd_line,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [LINE_BITS-1:0] wr_line
);

    logic [SETS-1:0]      valid_d, valid_q;
    logic [TAG_W-1:0]     tag_d  [SETS];
    logic [TAG_W-1:0]     tag_q  [SETS];
    logic [LINE_BITS-1:0] line_d [SETS];
    logic [LINE_BITS-1:0] line_q [SETS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

    always_comb begin
        valid_d = valid_q;
        for (int s = 0; s < SETS; s++) begin
            tag_d[s]  = tag_q[s];
            line_d[s] = line_q[s];
        end
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            tag_d[wr_idx]   = wr_tag;
            line_d[wr_idx]  = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
        for (int s = 0; s < SETS; s++) begin
            tag_q[s]  <= tag_d[s];
            line_q[s] <= line_d[s];
        end
    end

    // A slot that was just written must read back valid on the next cycle
    assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) || rd_valid);

endmodule

// File: rtl/dmc_victim_store.sv
module dmc_victim_store #(
    parameter int ENTRIES   = 4,
    parameter int LA_W      = 10,
    parameter int LINE_BITS = 128,
    localparam int PTR_W    = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LA_W-1:0]      look_la,
    output logic                 hit,
    output logic [PTR_W-1:0]     hit_idx,
    output logic [LINE_BITS-1:0] hit_line,
    input  logic                 wr_en,
    input  logic [PTR_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  logic [LA_W-1:0]      wr_la,
    input  logic [LINE_BITS-1:0] wr_line
);

    logic [ENTRIES-1:0]   valid_d, valid_q;
    logic [LA_W-1:0]      la_d   [ENTRIES];
    logic [LA_W-1:0]      la_q   [ENTRIES];
    logic [LINE_BITS-1:0] line_d [ENTRIES];
    logic [LINE_BITS-1:0] line_q [ENTRIES];
    logic [ENTRIES-1:0]   match;

    // Parallel comparators, one per entry
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = valid_q[e] && (la_q[e] == look_la);
    end

    always_comb begin
        hit      = |match;
        hit_idx  = '0;
        hit_line = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) begin
                hit_idx  = PTR_W'(e);
                hit_line = hit_line | line_q[e];
            end
        end
    end

    always_comb begin
        valid_d = valid_q;
        for (int e = 0; e < ENTRIES; e++) begin
            la_d[e]   = la_q[e];
            line_d[e] = line_q[e];
        end
        if (wr_en) begin
            valid_d[wr_idx] = wr_valid;
            la_d[wr_idx]    = wr_la;
            line_d[wr_idx]  = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
        for (int e = 0; e < ENTRIES; e++) begin
            la_q[e]   <= la_d[e];
            line_q[e] <= line_d[e];
        end
    end

    // No line may be held twice in the store
    assert_unique_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/dmc_victim_cache.sv
module dmc_victim_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 8,
    parameter int VICT_N     = 4,
    parameter int CNT_W      = 16,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int LA_W      = ADDR_W - OFF_W,
    localparam int LINE_BITS = WORD_W * LINE_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 fill_req_valid,
    input  logic                 fill_req_ready,
    output logic [LA_W-1:0]      fill_req_line,
    input  logic                 fill_rsp_valid,
    input  logic [LINE_BITS-1:0] fill_rsp_data,
    output logic [CNT_W-1:0]     cnt_main_hit,
    output logic [CNT_W-1:0]     cnt_victim_hit,
    output logic [CNT_W-1:0]     cnt_fill
);

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int VPTR_W = $clog2(VICT_N);

    typedef struct packed {
        dmc_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic                rsp_valid;
        logic [WORD_W-1:0]   rsp_data;
        logic [VPTR_W-1:0]   ptr;
        logic [CNT_W-1:0]    c_main;
        logic [CNT_W-1:0]    c_vict;
        logic [CNT_W-1:0]    c_fill;
    } regs_t;

    regs_t r_d, r_q;

    // Lookup address: incoming request when idle, held address otherwise
    logic [ADDR_W-1:0]    look_addr;
    logic [OFF_W-1:0]     look_off;
    logic [IDX_W-1:0]     look_idx;
    logic [TAG_W-1:0]     look_tag;
    logic [LA_W-1:0]      look_la;

    logic                 m_valid;
    logic [TAG_W-1:0]     m_tag;
    logic [LINE_BITS-1:0] m_line;
    logic                 m_hit;
    logic                 m_we;
    logic [LINE_BITS-1:0] m_wline;

    logic                 v_hit;
    logic [VPTR_W-1:0]    v_hit_idx;
    logic [LINE_BITS-1:0] v_line;
    logic                 v_we;
    logic [VPTR_W-1:0]    v_widx;

    assign look_addr = (r_q.state == ST_IDLE) ? req_addr : r_q.addr;
    assign look_off  = look_addr[OFF_W-1:0];
    assign look_idx  = look_addr[OFF_W +: IDX_W];
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
    assign look_la   = look_addr[ADDR_W-1:OFF_W];
    assign m_hit     = m_valid && (m_tag == look_tag);

    dmc_main_array #(
        .SETS      (SETS),
        .TAG_W     (TAG_W),
        .LINE_BITS (LINE_BITS)
    ) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_valid (m_valid),
        .rd_tag   (m_tag),
        .rd_line  (m_line),
        .wr_en    (m_we),
        .wr_idx   (look_idx),
        .wr_tag   (look_tag),
        .wr_line  (m_wline)
    );

    dmc_victim_store #(
        .ENTRIES   (VICT_N),
        .LA_W      (LA_W),
        .LINE_BITS (LINE_BITS)
    ) u_vict (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_la  (look_la),
        .hit      (v_hit),
        .hit_idx  (v_hit_idx),
        .hit_line (v_line),
        .wr_en    (v_we),
        .wr_idx   (v_widx),
        .wr_valid (m_valid),
        .wr_la    ({m_tag, look_idx}),
        .wr_line  (m_line)
    );

    always_comb begin
        r_d            = r_q;
        r_d.rsp_valid  = 1'b0;
        req_ready      = 1'b0;
        fill_req_valid = 1'b0;
        m_we           = 1'b0;
        m_wline        = fill_rsp_data;
        v_we           = 1'b0;
        v_widx         = r_q.ptr;

        unique case (r_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.addr = req_addr;
                    if (m_hit) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_data  = m_line[look_off*WORD_W +: WORD_W];
                        r_d.c_main    = r_q.c_main + CNT_W'(1);
                    end else if (v_hit) begin
                        r_d.state = ST_SWAP;
                    end else begin
                        r_d.state = ST_FREQ;
                    end
                end
            end
            ST_SWAP: begin
                // Victim line into the main slot, main line into the freed entry
                m_we          = 1'b1;
                m_wline       = v_line;
                v_we          = 1'b1;
                v_widx        = v_hit_idx;
                r_d.rsp_valid = 1'b1;
                r_d.rsp_data  = v_line[look_off*WORD_W +: WORD_W];
                r_d.c_vict    = r_q.c_vict + CNT_W'(1);
                r_d.state     = ST_IDLE;
            end
            ST_FREQ: begin
                fill_req_valid = 1'b1;
                if (fill_req_ready) begin
                    r_d.state = ST_FWAIT;
                end
            end
            ST_FWAIT: begin
                if (fill_rsp_valid) begin
                    m_we = 1'b1;
                    if (m_valid) begin
                        v_we    = 1'b1;
                        r_d.ptr = (r_q.ptr == VPTR_W'(VICT_N - 1)) ? '0
                                                                   : r_q.ptr + VPTR_W'(1);
                    end
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = fill_rsp_data[look_off*WORD_W +: WORD_W];
                    r_d.c_fill    = r_q.c_fill + CNT_W'(1);
                    r_d.state     = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid      = r_q.rsp_valid;
    assign rsp_data       = r_q.rsp_data;
    assign fill_req_line  = r_q.addr[ADDR_W-1:OFF_W];
    assign cnt_main_hit   = r_q.c_main;
    assign cnt_victim_hit = r_q.c_vict;
    assign cnt_fill       = r_q.c_fill;

    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && m_hit) |=> rsp_valid);

    assert_no_fill_on_victim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> !v_hit && !m_hit);

    assert_fill_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && !fill_req_ready) |=> fill_req_valid && $stable(fill_req_line));

    assert_fill_count_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_fill != $past(cnt_fill)) |-> $past(fill_rsp_valid) && rsp_valid);

    assert_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({cnt_main_hit != $past(cnt_main_hit),
                                  cnt_victim_hit != $past(cnt_victim_hit),
                                  cnt_fill != $past(cnt_fill)}) == 1);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !m_hit) |=> !req_ready);

endmodule

// File: tb/test_dmc_victim_cache.sv
module test_dmc_victim_cache;

    localparam int ADDR_W     = 12;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int SETS       = 8;
    localparam int VICT_N     = 4;
    localparam int CNT_W      = 16;
    localparam int OFF_W      = 2;
    localparam int LA_W       = ADDR_W - OFF_W;
    localparam int LINE_BITS  = WORD_W * LINE_WORDS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic                 rsp_valid;
    logic [WORD_W-1:0]    rsp_data;
    logic                 fill_req_valid;
    logic                 fill_req_ready = 1'b0;
    logic [LA_W-1:0]      fill_req_line;
    logic                 fill_rsp_valid = 1'b0;
    logic [LINE_BITS-1:0] fill_rsp_data = '0;
    logic [CNT_W-1:0]     cnt_main_hit, cnt_victim_hit, cnt_fill;

    always #2 clk = ~clk;

    dmc_victim_cache i_dmc_victim_cache (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .fill_req_valid (fill_req_valid),
        .fill_req_ready (fill_req_ready),
        .fill_req_line  (fill_req_line),
        .fill_rsp_valid (fill_rsp_valid),
        .fill_rsp_data  (fill_rsp_data),
        .cnt_main_hit   (cnt_main_hit),
        .cnt_victim_hit (cnt_victim_hit),
        .cnt_fill       (cnt_fill)
    );

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mem_word(input int la, input int w);
        return (WORD_W'(la) * 32'h9E37_79B1) ^ (WORD_W'(w) * 32'h0101_0101) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [LINE_BITS-1:0] mem_line(input int la);
        logic [LINE_BITS-1:0] l;
        for (int w = 0; w < LINE_WORDS; w++) l[w*WORD_W +: WORD_W] = mem_word(la, w);
        return l;
    endfunction

    // Behavioural next-level memory
    int fills_seen = 0;
    int last_line  = -1;
    int beat_cyc   = 0;
    bit hold_err   = 0;

    initial begin
        bit pend;
        int dly;
        int pline;
        bit was_wait;
        int wline;
        pend = 0; dly = 0; pline = 0; was_wait = 0; wline = 0;
        forever begin
            @(negedge clk);
            fill_rsp_valid = 1'b0;
            if (was_wait && (!fill_req_valid || fill_req_line != LA_W'(wline))) hold_err = 1;
            was_wait = 0;
            if (pend) begin
                if (dly == 0) begin
                    fill_rsp_valid = 1'b1;
                    fill_rsp_data  = mem_line(pline);
                    beat_cyc       = cyc;
                    pend           = 0;
                end else begin
                    dly--;
                end
                fill_req_ready = 1'b0;
            end else begin
                fill_req_ready = ($urandom % 3) != 0;
                if (fill_req_valid && fill_req_ready) begin
                    pend       = 1;
                    dly        = $urandom % 4;
                    pline      = int'(fill_req_line);
                    last_line  = pline;
                    fills_seen++;
                end else if (fill_req_valid) begin
                    was_wait = 1;
                    wline    = int'(fill_req_line);
                end
            end
        end
    end

    // Reference model state
    bit mv [SETS];
    int mt [SETS];
    bit vv [VICT_N];
    int vla[VICT_N];
    int vptr = 0;
    int exp_main = 0, exp_vict = 0, exp_fill = 0;

    // 0 main hit, 1 victim hit, 2 fill
    function automatic int predict_and_update(input int la);
        int idx, tag, disp;
        idx  = la % SETS;
        tag  = la / SETS;
        disp = mt[idx] * SETS + idx;
        if (mv[idx] && mt[idx] == tag) return 0;
        for (int k = 0; k < VICT_N; k++) begin
            if (vv[k] && vla[k] == la) begin
                vla[k] = disp;
                vv[k]  = mv[idx];
                mt[idx] = tag;
                return 1;
            end
        end
        if (mv[idx]) begin
            vla[vptr] = disp;
            vv[vptr]  = 1;
            vptr      = (vptr + 1) % VICT_N;
        end
        mv[idx] = 1;
        mt[idx] = tag;
        return 2;
    endfunction

    task automatic do_read(input logic [ADDR_W-1:0] a);
        int t0, f0, lat, kind, obs, la;
        bit busy_ok;
        la = int'(a >> OFF_W);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        t0 = cyc;
        f0 = fills_seen;
        kind = predict_and_update(la);
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = rsp_valid || !req_ready;
        while (!rsp_valid) @(negedge clk);
        lat = cyc - t0;
        obs = (fills_seen != f0) ? 2 : (lat == 1 ? 0 : (lat == 2 ? 1 : 3));
        case (kind)
            0: begin
                exp_main++;
                check(obs == 0, "R2", "main hit outcome", obs, 0);
                check(lat == 1, "R2", "main hit latency", lat, 1);
            end
            1: begin
                exp_vict++;
                check(obs == 1, "R6", "victim hit outcome", obs, 1);
                check(lat == 2, "R3", "victim hit latency", lat, 2);
                check(busy_ok, "R8", "ready low during swap", req_ready, 0);
            end
            default: begin
                exp_fill++;
                check(obs == 2, "R5", "memory fill outcome", obs, 2);
                check(last_line == la, "R4", "fill line address", last_line, la);
                check(cyc == beat_cyc + 1, "R4", "fill response timing", cyc, beat_cyc + 1);
                check(busy_ok, "R8", "ready low during fill", req_ready, 0);
            end
        endcase
        check(rsp_data == mem_word(la, int'(a[OFF_W-1:0])), "R2", "read data",
              rsp_data, mem_word(la, int'(a[OFF_W-1:0])));
        check(cnt_main_hit == CNT_W'(exp_main), "R7", "main hit counter", cnt_main_hit, exp_main);
        check(cnt_victim_hit == CNT_W'(exp_vict), "R7", "victim hit counter", cnt_victim_hit, exp_vict);
        check(cnt_fill == CNT_W'(exp_fill), "R7", "fill counter", cnt_fill, exp_fill);
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
        return ADDR_W'((tag * SETS + idx) * LINE_WORDS + off);
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < SETS; s++) begin mv[s] = 0; mt[s] = 0; end
        for (int k = 0; k < VICT_N; k++) begin vv[k] = 0; vla[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(fill_req_valid == 1'b0, "R1", "fill_req_valid after reset", fill_req_valid, 0);
        check(cnt_main_hit == 0 && cnt_victim_hit == 0 && cnt_fill == 0, "R1",
              "counters after reset", cnt_main_hit + cnt_victim_hit + cnt_fill, 0);
        // R1: first access to any line must fill (all entries invalid)
        do_read(mk(0, 0, 0));
        check(exp_fill == 1, "R1", "cold access fills", exp_fill, 1);
        // Ping-pong on one set: victim swaps instead of memory
        do_read(mk(1, 0, 3));
        do_read(mk(0, 0, 1));
        do_read(mk(1, 0, 2));
        do_read(mk(1, 0, 0));
        check(cnt_victim_hit == 2, "R6", "ping-pong victim hits", cnt_victim_hit, 2);
        // Six lines on set 2: FIFO wrap evicts oldest insertion
        for (int t = 0; t < 6; t++) do_read(mk(t, 2, t % LINE_WORDS));
        do_read(mk(0, 2, 1));
        check(fills_seen == exp_fill, "R5", "FIFO evicted line refetched", fills_seen, exp_fill);
        do_read(mk(5, 2, 3));
        // Random conflict-heavy traffic
        for (int n = 0; n < 500; n++) begin
            do_read(mk(int'($urandom % 8), int'(($urandom % 4) * 2), int'($urandom % LINE_WORDS)));
        end
        check(!hold_err, "R4", "fill request held until ready", hold_err, 0);
        check(fills_seen == int'(cnt_fill), "R4", "memory requests equal fills", fills_seen, cnt_fill);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule